// File: doc/BRIEF.md
# Dual-Clock FIFO with Five-Level Fill Flags

This block is a first-in first-out word buffer whose write port and read port each run on their own rising-edge clock. A word enters on a write clock edge while the active-low write enable is low and the buffer has room. The next stored word is loaded into the output register on a read clock edge while the active-low read enable is low and the buffer holds data. Depth and word width are parameters; the default is 1024 words of 36 bits, and the depth must be a power of two. The two clocks may be unrelated, or they may be one net for single-clock use.

The port has no valid/ready handshake. Back-pressure works through the flags alone. A write attempted while the write side sees the buffer as full is dropped, and so is a read attempted while the read side sees it as empty. Either attempt latches the fault flag.

Fill level is reported on four active-low status pins:
- a shared empty-or-full pin;
- a shared quarter-or-three-quarter pin;
- a half-full pin;
- a fault pin.

The conditions on the read side of the fill (empty, quarter, empty-fault) are registered on the read clock. The conditions on the write side (full, three-quarter, half, full-fault) are registered on the write clock. A pin that carries conditions from both sides combines them without further logic. The pointers cross between the domains as Gray code through two-flop synchronizers, so activity on one side reaches the other side's flags a few of that side's clocks later.

An active-low master reset empties the buffer, clears the flags and zeroes the output register. An active-low output enable gates the data bus.

Top module: `dcfifo_levels`

## Requirements
- R1: On a rising `wr_clk`, a word is stored only when `wr_en_n` is low and the write side does not see the buffer as full. A write attempted when full leaves the stored contents unchanged.
- R2: On a rising `rd_clk`, the oldest stored word is loaded into the output register only when `rd_en_n` is low and the read side does not see the buffer as empty. Otherwise the output register holds its value.
- R3: Words leave in the order they were accepted, with no loss and no duplication, also under simultaneous traffic on unrelated clocks.
- R4: The flags form a 4-bit code {`flt_n`,`ef_n`,`qt_n`,`hf_n`}, all active low, which depends on the settled word count n with D = DEPTH. The codes are:
  - n = 0 gives 1001;
  - 1 ≤ n ≤ D/4 gives 1101;
  - D/4 < n ≤ D/2 gives 1111;
  - D/2 < n < 3D/4 gives 1110;
  - 3D/4 ≤ n < D gives 1100;
  - n = D gives 1000.
- R5: `hf_n` is low exactly when strictly more than D/2 words are held, as seen by the write side.
- R6: `qt_n` is low when the read side sees D/4 or fewer words, or when the write side sees D/4 or fewer free locations. It is high only between those two bounds.
- R7: A read attempted while empty drives `flt_n` low, giving the code 0001. The fault stays latched until the read side no longer sees the buffer as empty.
- R8: A write attempted while full drives `flt_n` low, giving the code 0000. The fault stays latched until the write side no longer sees the buffer as full.
- R9: While `mrst_n` is low, the buffer empties and all flag state clears. After release, the code is 1001 and `rd_q` reads all zero until the first read.
- R10: With `oe_n` high, `rd_q` is all zero and `rd_q_drv` is low. With `oe_n` low, `rd_q` shows the output register and `rd_q_drv` is high.
- R11: Activity on one side reaches the other side's flags within a few clocks of that other side. Once both ports are idle, the code settles to the value R4 gives for the true count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock, rising edge |
| rd_clk | input | 1 | Read clock, rising edge |
| mrst_n | input | 1 | Master reset, active low, asynchronous |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | WIDTH | Word to store |
| rd_en_n | input | 1 | Read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_q | output | WIDTH | Output word, zero while disabled |
| rd_q_drv | output | 1 | High while `rd_q` is driven |
| flt_n | output | 1 | Fault flag, active low |
| ef_n | output | 1 | Empty-or-full flag, active low |
| qt_n | output | 1 | Quarter-or-three-quarter flag, active low |
| hf_n | output | 1 | More-than-half flag, active low |

## Verification
The assertions assume that each enable is steady around its own clock edge and that master reset is held across at least one edge of each clock. They also assume that DEPTH is a power of two, so the extra pointer bit wraps cleanly. The stimulus changes each enable only on the falling edge of its own clock and holds reset for several cycles of both clocks. During concurrent traffic, the stimulus raises a read only when the empty-or-full pin shows data present, and it throttles writes well below the depth. This keeps the synchronizer lag on the full side from mattering.

// File: rtl/dcfifo_levels_pkg.sv
`timescale 1ns/1ps
package dcfifo_levels_pkg;
  // status registered on the read clock
  typedef struct packed {
    logic empty;
    logic qtr;
  } rd_view_t;

  // status registered on the write clock
  typedef struct packed {
    logic full;
    logic half;
    logic tqtr;
  } wr_view_t;
endpackage

// File: rtl/dcfifo_levels_xfer.sv
`timescale 1ns/1ps
// Two-flop Gray pointer synchronizer with binary decode on the far side.
module dcfifo_levels_xfer #(
  parameter int PW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] gray_i,
  output logic [PW-1:0] bin_o
);
  logic [PW-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_i;
      sync_q <= meta_q;
    end
  end

  for (genvar g = 0; g < PW; g++) begin : g_dec
    assign bin_o[g] = ^(sync_q >> g);
  end
endmodule

// File: rtl/dcfifo_levels_ram.sv
`timescale 1ns/1ps
module dcfifo_levels_ram #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 36,
  parameter int AW    = 10
) (
  input  logic             wclk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/dcfifo_levels_wr.sv
`timescale 1ns/1ps
module dcfifo_levels_wr
  import dcfifo_levels_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = 10,
  parameter int PW    = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_n,
  input  logic [PW-1:0] rbin_s,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray,
  output wr_view_t      st,
  output logic          fault
);
  localparam logic [PW-1:0] LIM_FULL = PW'(DEPTH);
  localparam logic [PW-1:0] LIM_HALF = PW'(DEPTH / 2);
  localparam logic [PW-1:0] LIM_TQ   = PW'(DEPTH - DEPTH / 4);

  logic [PW-1:0] wbin, wbin_nx, fill_nx, fill_now;

  assign we       = ~en_n & ~st.full;
  assign wbin_nx  = wbin + PW'(we);
  assign fill_nx  = wbin_nx - rbin_s;
  assign fill_now = wbin - rbin_s;
  assign waddr    = wbin[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      st    <= '0;
      fault <= 1'b0;
    end else begin
      wbin    <= wbin_nx;
      wgray   <= wbin_nx ^ (wbin_nx >> 1);
      st.full <= (fill_nx == LIM_FULL);
      st.half <= (fill_nx > LIM_HALF);
      st.tqtr <= (fill_nx >= LIM_TQ);
      fault   <= (~en_n & st.full) | (fault & (fill_nx == LIM_FULL));
    end
  end

  AST_WR_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_now <= LIM_FULL); // R1
  AST_FULL_NESTS: assert property (@(posedge clk) disable iff (!rst_n)
    st.full |-> (st.tqtr && st.half)); // R6
  AST_WFAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(st.full && !en_n)); // R8
endmodule

// File: rtl/dcfifo_levels_rd.sv
`timescale 1ns/1ps
module dcfifo_levels_rd
  import dcfifo_levels_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = 10,
  parameter int PW    = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_n,
  input  logic [PW-1:0] wbin_s,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output rd_view_t      st,
  output logic          fault
);
  localparam logic [PW-1:0] LIM_FULL = PW'(DEPTH);
  localparam logic [PW-1:0] LIM_QTR  = PW'(DEPTH / 4);

  logic [PW-1:0] rbin, rbin_nx, fill_nx, fill_now;

  assign re       = ~en_n & ~st.empty;
  assign rbin_nx  = rbin + PW'(re);
  assign fill_nx  = wbin_s - rbin_nx;
  assign fill_now = wbin_s - rbin;
  assign raddr    = rbin[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      st.empty <= 1'b1;
      st.qtr   <= 1'b1;
      fault    <= 1'b0;
    end else begin
      rbin     <= rbin_nx;
      rgray    <= rbin_nx ^ (rbin_nx >> 1);
      st.empty <= (fill_nx == '0);
      st.qtr   <= (fill_nx <= LIM_QTR);
      fault    <= (~en_n & st.empty) | (fault & (fill_nx == '0));
    end
  end

  AST_RD_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_now <= LIM_FULL); // R2
  AST_EMPTY_NESTS: assert property (@(posedge clk) disable iff (!rst_n)
    st.empty |-> st.qtr); // R6
  AST_RFAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(st.empty && !en_n)); // R7
endmodule

// File: rtl/dcfifo_levels.sv
`timescale 1ns/1ps
module dcfifo_levels
  import dcfifo_levels_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 36
) (
  input  logic             wr_clk,
  input  logic             rd_clk,
  input  logic             mrst_n,
  input  logic             wr_en_n,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en_n,
  input  logic             oe_n,
  output logic [WIDTH-1:0] rd_q,
  output logic             rd_q_drv,
  output logic             flt_n,
  output logic             ef_n,
  output logic             qt_n,
  output logic             hf_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic             we, re, wfault, rfault;
  logic [AW-1:0]    waddr, raddr;
  logic [PW-1:0]    wgray, rgray, wbin_s, rbin_s;
  logic [WIDTH-1:0] ram_q, dout_q;
  wr_view_t         wst;
  rd_view_t         rst_v;

  dcfifo_levels_wr #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
    .clk(wr_clk), .rst_n(mrst_n), .en_n(wr_en_n), .rbin_s(rbin_s),
    .we(we), .waddr(waddr), .wgray(wgray), .st(wst), .fault(wfault));

  dcfifo_levels_rd #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_rd (
    .clk(rd_clk), .rst_n(mrst_n), .en_n(rd_en_n), .wbin_s(wbin_s),
    .re(re), .raddr(raddr), .rgray(rgray), .st(rst_v), .fault(rfault));

  dcfifo_levels_xfer #(.PW(PW)) u_w2r (
    .clk(rd_clk), .rst_n(mrst_n), .gray_i(wgray), .bin_o(wbin_s));

  dcfifo_levels_xfer #(.PW(PW)) u_r2w (
    .clk(wr_clk), .rst_n(mrst_n), .gray_i(rgray), .bin_o(rbin_s));

  dcfifo_levels_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_ram (
    .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(ram_q));

  always_ff @(posedge rd_clk or negedge mrst_n) begin
    if (!mrst_n)  dout_q <= '0;
    else if (re)  dout_q <= ram_q;
  end

  // shared pins: each half comes from its own clock domain
  assign ef_n     = ~(rst_v.empty | wst.full);
  assign qt_n     = ~(rst_v.qtr | wst.tqtr);
  assign hf_n     = ~wst.half;
  assign flt_n    = ~(rfault | wfault);
  assign rd_q     = oe_n ? '0 : dout_q;
  assign rd_q_drv = ~oe_n;

  AST_DOUT_HOLD: assert property (@(posedge rd_clk) disable iff (!mrst_n)
    rd_en_n |=> $stable(dout_q)); // R2
endmodule

// File: tb/sim_dcfifo_levels.sv
`timescale 1ns/1ps
module sim_dcfifo_levels;
  localparam int DEPTH = 1024;
  localparam int WIDTH = 36;

  logic wclk = 1'b0, rclk = 1'b0;
  logic mrst_n, wr_en_n, rd_en_n, oe_n;
  logic [WIDTH-1:0] wr_data, rd_q;
  logic rd_q_drv, flt_n, ef_n, qt_n, hf_n;

  always #2   wclk = ~wclk;  // 250 MHz
  always #3.5 rclk = ~rclk;  // unrelated read clock

  dcfifo_levels #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
    .wr_clk(wclk), .rd_clk(rclk), .mrst_n(mrst_n), .wr_en_n(wr_en_n),
    .wr_data(wr_data), .rd_en_n(rd_en_n), .oe_n(oe_n), .rd_q(rd_q),
    .rd_q_drv(rd_q_drv), .flt_n(flt_n), .ef_n(ef_n), .qt_n(qt_n), .hf_n(hf_n));

  logic [WIDTH-1:0] sb[$];
  int n_cmp = 0, n_bad = 0, mcount = 0, seq = 0, rx_cnt = 0;
  logic rd_expect = 1'b0, pop_due = 1'b0;
  logic [WIDTH-1:0] last_pop = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
    end
  endtask

  function automatic logic [3:0] exp_code(input int n, input bit rf, input bit wf);
    logic f, e, q, h;
    f = ~(rf | wf);
    e = ~((n == 0) || (n == DEPTH));
    q = ~((n <= DEPTH / 4) || (n >= DEPTH - DEPTH / 4));
    h = ~(n > DEPTH / 2);
    return {f, e, q, h};
  endfunction

  function automatic logic [WIDTH-1:0] mkdata(input int s);
    logic [63:0] v;
    v = 64'(s) * 64'h9E37_79B9_7F4A_7C15;
    return v[63:64-WIDTH];
  endfunction

  task automatic chk_code(input string req, input int n, input bit rf, input bit wf);
    logic [3:0] e;
    e = exp_code(n, rf, wf);
    chk({flt_n, ef_n, qt_n, hf_n} == e, req, 64'({flt_n, ef_n, qt_n, hf_n}), 64'(e));
  endtask

  task automatic settle();
    repeat (8) @(posedge wclk);
    repeat (8) @(posedge rclk);
    @(negedge rclk);
  endtask

  // driver: each accepted word goes into the scoreboard
  task automatic push_words(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wr_en_n = 1'b0;
      wr_data = mkdata(seq);
      seq++;
      if (mcount < DEPTH) begin
        sb.push_back(wr_data);
        mcount++;
      end
    end
    @(negedge wclk);
    wr_en_n = 1'b1;
  endtask

  task automatic pull_words(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge rclk);
      rd_en_n = 1'b0;
      rd_expect = (mcount > 0);
      if (mcount > 0) mcount--;
    end
    @(negedge rclk);
    rd_en_n = 1'b1;
    rd_expect = 1'b0;
  endtask

  // monitor: compare every read result against the scoreboard
  always @(posedge rclk) pop_due <= !rd_en_n && rd_expect;
  always @(negedge rclk) begin
    if (pop_due) begin
      if (sb.size() == 0) chk(1'b0, "R3 underflow", 64'(rd_q), 64'h0);
      else begin
        last_pop = sb.pop_front();
        chk(rd_q == last_pop, "R3 order/R2 read", 64'(rd_q), 64'(last_pop));
      end
      rx_cnt++;
    end
  end

  initial begin
    #700000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int lv[9];
    logic [WIDTH-1:0] held;
    mrst_n = 1'b0; wr_en_n = 1'b1; rd_en_n = 1'b1; oe_n = 1'b0; wr_data = '0;
    repeat (5) @(negedge wclk);
    mrst_n = 1'b1;
    settle();
    chk_code("R9 reset code", 0, 0, 0);
    chk(rd_q == '0, "R9 reset data", 64'(rd_q), 64'h0);

    // R4 R5 R6: fill through each level boundary
    lv = '{1, 256, 257, 512, 513, 767, 768, 1023, 1024};
    foreach (lv[i]) begin
      push_words(lv[i] - mcount);
      settle();
      chk_code("R4 level up (R5 R6)", mcount, 0, 0);
    end

    // R8: write while full is refused and latches the fault
    push_words(1);
    #1;
    chk_code("R8 full fault", DEPTH, 0, 1);
    settle();
    chk_code("R8 full fault latched", DEPTH, 0, 1);
    pull_words(1);
    settle();
    chk_code("R8 fault cleared", DEPTH - 1, 0, 0);

    // R10: output enable gates the bus
    oe_n = 1'b1; #1;
    chk(rd_q == '0 && !rd_q_drv, "R10 released", 64'({rd_q_drv, rd_q}), 64'h0);
    oe_n = 1'b0; #1;
    chk(rd_q == last_pop && rd_q_drv, "R10 driven", 64'(rd_q), 64'(last_pop));

    // drain through the boundaries (R1: refused word never appears)
    lv = '{768, 767, 513, 512, 257, 256, 1, 0, 0};
    for (int i = 0; i < 8; i++) begin
      pull_words(mcount - lv[i]);
      settle();
      chk_code("R4 level down (R6)", mcount, 0, 0);
    end

    // R7: read while empty
    held = rd_q;
    @(negedge rclk); rd_en_n = 1'b0; rd_expect = 1'b0;
    @(negedge rclk); rd_en_n = 1'b1;
    #1;
    chk_code("R7 empty fault", 0, 1, 0);
    chk(rd_q == held, "R2 hold when empty", 64'(rd_q), 64'(held));
    settle();
    chk_code("R7 empty fault latched", 0, 1, 0);
    push_words(1);
    settle();
    chk_code("R7 fault cleared", 1, 0, 0);
    pull_words(1);
    settle();

    // R3 R11: concurrent traffic on unrelated clocks
    rx_cnt = 0;
    fork
      begin : writer
        int sent;
        sent = 0;
        while (sent < 700) begin
          @(negedge wclk);
          if (mcount < DEPTH - 16) begin
            wr_en_n = 1'b0;
            wr_data = mkdata(seq);
            seq++;
            sb.push_back(wr_data);
            mcount++;
            sent++;
          end else wr_en_n = 1'b1;
        end
        @(negedge wclk);
        wr_en_n = 1'b1;
      end
      begin : reader
        while (rx_cnt < 700) begin
          @(negedge rclk);
          if (ef_n && mcount > 0) begin
            rd_en_n = 1'b0; rd_expect = 1'b1; mcount--;
          end else begin
            rd_en_n = 1'b1; rd_expect = 1'b0;
          end
        end
        rd_en_n = 1'b1; rd_expect = 1'b0;
      end
    join
    settle();
    chk(rx_cnt == 700, "R3 all words delivered", 64'(rx_cnt), 64'd700);
    chk_code("R11 settled after traffic", 0, 0, 0);

    // R9: mid-run reset empties the buffer
    push_words(300);
    settle();
    chk_code("R4 before reset", 300, 0, 0);
    @(negedge wclk); mrst_n = 1'b0;
    repeat (4) @(negedge rclk);
    mrst_n = 1'b1;
    sb.delete(); mcount = 0;
    settle();
    chk_code("R9 code after reset", 0, 0, 0);
    chk(rd_q == '0, "R9 data zero", 64'(rd_q), 64'h0);
    push_words(2);
    settle();
    chk_code("R11 one side to other", 2, 0, 0);
    pull_words(2);
    settle();
    chk(sb.size() == 0, "R9 fresh data only", 64'(sb.size()), 64'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule